// File: doc/BRIEF.md
# Single-Byte NOR Flash Program Controller

This block sits on the host side of a parallel NOR flash and stores one byte per request. A request carries a target address, a data byte and a flag that asks for a check before programming. The controller then works through the program sequence on its own. It drives three unlock and command writes, followed by the write of the byte itself. It then reads the target location until bit 7 of the returned value equals bit 7 of the byte written. A final read compares the whole stored byte against the request.

The flash cannot turn a stored 0 back into a 1. An attempt to do so can leave the device busy for ever, or let it report completion while the cell still holds 0. The final comparison turns the second outcome into a fail, and the poll limit turns the first into a timeout. When the pre-check flag is set, the controller reads the target before anything else. If the new byte needs any bit raised from 0 to 1, it rejects the request without writing.

Requests enter on a valid/ready handshake. `req_ready` is high only while the controller is idle. A request is taken on a rising clock edge that sees both `req_valid` and `req_ready` high. While `req_ready` is low, `req_valid` is ignored, and a source that is held off must keep or re-present its request after the next `done`. The result pins are plain levels, plus a one-cycle `done`.

Top module: `flash_byte_prog`

## Requirements
- R1: `req_ready` is high exactly when the controller is idle, and it drops the cycle after a request is taken. A `req_valid` seen while `req_ready` is low starts nothing and changes neither the writes, the target nor the result of the operation in progress.
- R2: Unless a request is rejected by the pre-check, it produces exactly four flash writes, in this order of (address, data): (0x555, 0xAA), (0x2AA, 0x55), (0x555, 0xA0), (target, data byte). The first three pairs are parameters, with these defaults.
- R3: In every write, `fl_ce_n` is low and the address and data are driven for T_SETUP cycles before `fl_we_n` falls. `fl_we_n` stays low for T_PULSE cycles. Address and data remain unchanged, with `fl_ce_n` low, for T_HOLD cycles after `fl_we_n` rises.
- R4: `fl_we_n` and `fl_oe_n` are never low in the same cycle, and `fl_dq_oe` is low whenever `fl_oe_n` is low.
- R5: Every read the controller makes (pre-check, status poll, final verify) uses the target address. Polling ends when bit 7 of a read equals bit 7 of the data byte.
- R6: After polling ends, one more read of the target is made. The result is pass if it equals the data byte and fail otherwise.
- R7: With `req_precheck` high, the target is read first. If (stored AND new) differs from new, the request ends as a fail with no flash write. Otherwise it proceeds as in R2.
- R8: After max(`poll_limit`, 1) status reads without a bit-7 match, the request ends with `timeout` and the controller returns to idle. `poll_limit` is sampled when the request is taken.
- R9: `done` is high for a single cycle per request. In that cycle exactly one of `pass`, `fail`, `timeout` is high, and these three keep their values until the next `done`.
- R10: After reset, `req_ready` is 1, `fl_ce_n`, `fl_we_n` and `fl_oe_n` are 1, and `fl_dq_oe`, `done`, `pass`, `fail` and `timeout` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request can be taken |
| req_addr | input | AW | Target flash address |
| req_data | input | DW | Byte to store |
| req_precheck | input | 1 | Read target and reject 0-to-1 requests before writing |
| poll_limit | input | PW | Maximum number of status reads (0 acts as 1) |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Last request stored correctly |
| fail | output | 1 | Last request rejected or read back wrong |
| timeout | output | 1 | Last request exceeded the poll limit |
| fl_ce_n | output | 1 | Flash chip enable, active low |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_oe_n | output | 1 | Flash output enable, active low |
| fl_addr | output | AW | Flash address bus |
| fl_dq_o | output | DW | Data driven toward the flash |
| fl_dq_oe | output | 1 | Enable of the data bus drivers |
| fl_dq_i | input | DW | Data returned by the flash |

## Verification
Each bus cycle lasts T_SETUP + T_PULSE + T_HOLD cycles and is followed by two cycles with chip enable high. The number of polls depends on how long the flash model stays busy. For that reason the bench does not wait a fixed number of cycles for the outcome. It samples `done` on every falling clock edge and reads the three result flags in the cycle where `done` is seen, then checks one cycle later that `done` has dropped. Write timing is measured cycle by cycle on falling edges, per bus cycle, against the exact T_SETUP, T_PULSE and T_HOLD counts. Write order and read addresses are logged on the strobe edges and compared once the request has finished.

// File: rtl/fbp_pkg.sv
package fbp_pkg;
  typedef enum logic [1:0] {
    PH_IDLE,
    PH_SETUP,
    PH_PULSE,
    PH_HOLD
  } bus_phase_t;

  typedef enum logic [2:0] {
    SQ_IDLE,
    SQ_PRECHK,
    SQ_WRITE,
    SQ_POLL,
    SQ_VERIFY
  } seq_state_t;
endpackage

// File: rtl/fbp_bus_engine.sv
module fbp_bus_engine #(
  parameter int AW      = 22,
  parameter int DW      = 8,
  parameter int T_SETUP = 2,
  parameter int T_PULSE = 4,
  parameter int T_HOLD  = 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_write,
  input  logic [AW-1:0] go_addr,
  input  logic [DW-1:0] go_data,
  output logic          cyc_done,
  output logic [DW-1:0] rd_data,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_o,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_i
);
  import fbp_pkg::*;

  localparam int TMAX = (T_SETUP > T_PULSE) ? ((T_SETUP > T_HOLD) ? T_SETUP : T_HOLD)
                                            : ((T_PULSE > T_HOLD) ? T_PULSE : T_HOLD);
  localparam int CW = $clog2(TMAX + 1);

  bus_phase_t    ph;
  logic [CW-1:0] cnt;
  logic          is_wr;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      cnt      <= '0;
      is_wr    <= 1'b0;
      addr_q   <= '0;
      data_q   <= '0;
      rd_data  <= '0;
      cyc_done <= 1'b0;
    end else begin
      cyc_done <= 1'b0;
      unique case (ph)
        PH_IDLE: if (go) begin
          ph     <= PH_SETUP;
          cnt    <= CW'(T_SETUP - 1);
          is_wr  <= go_write;
          addr_q <= go_addr;
          data_q <= go_data;
        end
        PH_SETUP: if (cnt == '0) begin
          ph  <= PH_PULSE;
          cnt <= CW'(T_PULSE - 1);
        end else cnt <= cnt - 1'b1;
        PH_PULSE: if (cnt == '0) begin
          if (!is_wr) rd_data <= fl_dq_i;
          ph  <= PH_HOLD;
          cnt <= CW'(T_HOLD - 1);
        end else cnt <= cnt - 1'b1;
        PH_HOLD: if (cnt == '0) begin
          ph       <= PH_IDLE;
          cyc_done <= 1'b1;
        end else cnt <= cnt - 1'b1;
        default: ph <= PH_IDLE;
      endcase
    end
  end

  // Strobes come straight from the phase register; read and write never share a phase.
  assign fl_ce_n  = (ph == PH_IDLE);
  assign fl_we_n  = !((ph == PH_PULSE) && is_wr);
  assign fl_oe_n  = !((ph == PH_PULSE) && !is_wr);
  assign fl_dq_oe = is_wr && (ph != PH_IDLE);
  assign fl_addr  = addr_q;
  assign fl_dq_o  = data_q;
endmodule

// File: rtl/fbp_cmd_sel.sv
module fbp_cmd_sel #(
  parameter int AW = 22,
  parameter int DW = 8,
  parameter logic [AW-1:0] A_FIRST  = AW'('h555),
  parameter logic [AW-1:0] A_SECOND = AW'('h2AA),
  parameter logic [DW-1:0] D_FIRST  = DW'('hAA),
  parameter logic [DW-1:0] D_SECOND = DW'('h55),
  parameter logic [DW-1:0] D_PROG   = DW'('hA0)
) (
  input  logic [1:0]    idx,
  input  logic [AW-1:0] tgt_addr,
  input  logic [DW-1:0] tgt_data,
  output logic [AW-1:0] cmd_addr,
  output logic [DW-1:0] cmd_data
);
  always_comb begin
    unique case (idx)
      2'd0:    begin cmd_addr = A_FIRST;  cmd_data = D_FIRST;  end
      2'd1:    begin cmd_addr = A_SECOND; cmd_data = D_SECOND; end
      2'd2:    begin cmd_addr = A_FIRST;  cmd_data = D_PROG;   end
      default: begin cmd_addr = tgt_addr; cmd_data = tgt_data; end
    endcase
  end
endmodule

// File: rtl/fbp_poll_ctr.sv
module fbp_poll_ctr #(
  parameter int PW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          inc,
  input  logic [PW-1:0] limit,
  output logic          last
);
  logic [PW-1:0] cnt;
  logic [PW-1:0] lim_q;
  logic [PW:0]   eff;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt   <= '0;
      lim_q <= '0;
    end else if (clr) begin
      cnt   <= '0;
      lim_q <= limit;
    end else if (inc) begin
      cnt <= cnt + 1'b1;
    end
  end

  assign eff  = (lim_q == '0) ? (PW+1)'(1) : {1'b0, lim_q};
  assign last = ({1'b0, cnt} + (PW+1)'(1)) >= eff;
endmodule

// File: rtl/flash_byte_prog.sv
module flash_byte_prog #(
  parameter int AW       = 22,
  parameter int DW       = 8,
  parameter int PW       = 16,
  parameter int T_SETUP  = 2,
  parameter int T_PULSE  = 4,
  parameter int T_HOLD   = 1,
  parameter int POLL_BIT = 7,
  parameter logic [AW-1:0] A_FIRST  = AW'('h555),
  parameter logic [AW-1:0] A_SECOND = AW'('h2AA),
  parameter logic [DW-1:0] D_FIRST  = DW'('hAA),
  parameter logic [DW-1:0] D_SECOND = DW'('h55),
  parameter logic [DW-1:0] D_PROG   = DW'('hA0)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_data,
  input  logic          req_precheck,
  input  logic [PW-1:0] poll_limit,
  output logic          done,
  output logic          pass,
  output logic          fail,
  output logic          timeout,
  output logic          fl_ce_n,
  output logic          fl_we_n,
  output logic          fl_oe_n,
  output logic [AW-1:0] fl_addr,
  output logic [DW-1:0] fl_dq_o,
  output logic          fl_dq_oe,
  input  logic [DW-1:0] fl_dq_i
);
  import fbp_pkg::*;

  seq_state_t    st;
  logic [1:0]    wr_idx;
  logic [AW-1:0] t_addr;
  logic [DW-1:0] t_data;
  logic          launch;
  logic          cyc_done;
  logic [DW-1:0] rd_data;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_data;
  logic          poll_last;
  logic          take;
  logic          bit_match;
  logic          poll_inc;

  assign req_ready = (st == SQ_IDLE);
  assign take      = req_valid && req_ready;
  assign bit_match = (rd_data[POLL_BIT] == t_data[POLL_BIT]);
  assign poll_inc  = (st == SQ_POLL) && cyc_done && !bit_match && !poll_last;

  fbp_cmd_sel #(
    .AW(AW), .DW(DW), .A_FIRST(A_FIRST), .A_SECOND(A_SECOND),
    .D_FIRST(D_FIRST), .D_SECOND(D_SECOND), .D_PROG(D_PROG)
  ) u_cmd (
    .idx(wr_idx), .tgt_addr(t_addr), .tgt_data(t_data),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data)
  );

  fbp_poll_ctr #(.PW(PW)) u_poll (
    .clk(clk), .rst_n(rst_n), .clr(take), .inc(poll_inc),
    .limit(poll_limit), .last(poll_last)
  );

  fbp_bus_engine #(
    .AW(AW), .DW(DW), .T_SETUP(T_SETUP), .T_PULSE(T_PULSE), .T_HOLD(T_HOLD)
  ) u_bus (
    .clk(clk), .rst_n(rst_n), .go(launch), .go_write(st == SQ_WRITE),
    .go_addr((st == SQ_WRITE) ? cmd_addr : t_addr), .go_data(cmd_data),
    .cyc_done(cyc_done), .rd_data(rd_data),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
    .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= SQ_IDLE;
      wr_idx  <= '0;
      t_addr  <= '0;
      t_data  <= '0;
      launch  <= 1'b0;
      done    <= 1'b0;
      pass    <= 1'b0;
      fail    <= 1'b0;
      timeout <= 1'b0;
    end else begin
      launch <= 1'b0;
      done   <= 1'b0;
      unique case (st)
        SQ_IDLE: if (take) begin
          t_addr <= req_addr;
          t_data <= req_data;
          wr_idx <= '0;
          launch <= 1'b1;
          st     <= req_precheck ? SQ_PRECHK : SQ_WRITE;
        end
        SQ_PRECHK: if (cyc_done) begin
          if ((rd_data & t_data) != t_data) begin
            st <= SQ_IDLE; done <= 1'b1;
            pass <= 1'b0; fail <= 1'b1; timeout <= 1'b0;
          end else begin
            st <= SQ_WRITE; launch <= 1'b1;
          end
        end
        SQ_WRITE: if (cyc_done) begin
          launch <= 1'b1;
          if (wr_idx == 2'd3) st <= SQ_POLL;
          else wr_idx <= wr_idx + 1'b1;
        end
        SQ_POLL: if (cyc_done) begin
          if (bit_match) begin
            st <= SQ_VERIFY; launch <= 1'b1;
          end else if (poll_last) begin
            st <= SQ_IDLE; done <= 1'b1;
            pass <= 1'b0; fail <= 1'b0; timeout <= 1'b1;
          end else begin
            launch <= 1'b1;
          end
        end
        SQ_VERIFY: if (cyc_done) begin
          st <= SQ_IDLE; done <= 1'b1;
          pass <= (rd_data == t_data); fail <= (rd_data != t_data); timeout <= 1'b0;
        end
        default: st <= SQ_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fbp_chk.sv
module fbp_chk #(
  parameter int AW = 22,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          done,
  input logic          pass,
  input logic          fail,
  input logic          timeout,
  input logic          fl_ce_n,
  input logic          fl_we_n,
  input logic          fl_oe_n,
  input logic [AW-1:0] fl_addr,
  input logic [DW-1:0] fl_dq_o,
  input logic          fl_dq_oe
);
  // R4
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!fl_we_n && !fl_oe_n));
  // R4
  bus_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_oe_n |-> !fl_dq_oe);
  // R3
  we_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |-> (!fl_ce_n && fl_dq_oe));
  // R3
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !fl_we_n |=> ($stable(fl_dq_o) && $stable(fl_addr) && !fl_ce_n));
  // R1
  busy_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R9
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ($countones({pass, fail, timeout}) == 1));
  // R9
  result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({pass, fail, timeout}));
endmodule

bind flash_byte_prog fbp_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .done(done), .pass(pass), .fail(fail), .timeout(timeout),
  .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n),
  .fl_addr(fl_addr), .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe)
);

// File: tb/sim_flash_byte_prog.sv
module sim_flash_byte_prog;
  localparam int AW = 12, DW = 8, PW = 16, TS = 2, TP = 3, TH = 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 1'b0, req_precheck = 1'b0;
  logic req_ready;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_data = '0;
  logic [PW-1:0] poll_limit = '0;
  logic done, pass, fail, timeout;
  logic fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dq_o, fl_dq_i;

  always #2 clk = ~clk;

  flash_byte_prog #(.AW(AW), .DW(DW), .PW(PW), .T_SETUP(TS), .T_PULSE(TP), .T_HOLD(TH)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_precheck(req_precheck),
    .poll_limit(poll_limit), .done(done), .pass(pass), .fail(fail), .timeout(timeout),
    .fl_ce_n(fl_ce_n), .fl_we_n(fl_we_n), .fl_oe_n(fl_oe_n), .fl_addr(fl_addr),
    .fl_dq_o(fl_dq_o), .fl_dq_oe(fl_dq_oe), .fl_dq_i(fl_dq_i)
  );

  int vectors = 0, fails = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  // ---- flash model ----
  logic [7:0] mem [0:(1<<AW)-1];
  logic mbusy = 0, mhang = 0, armed = 0, tog = 0;
  int mcnt = 0, mst = 0;
  logic [AW-1:0] maddr = '0, cur_tgt = '0;
  logic [7:0] mdat = '0;
  logic [AW-1:0] wa [0:7];
  logic [7:0] wd [0:7];
  int nwr = 0, nrd = 0, bad_rd = 0;

  assign fl_dq_i = (!fl_oe_n && !fl_ce_n) ? (mbusy ? {~mdat[7], tog, 6'd0} : mem[fl_addr]) : 8'h00;

  always @(posedge fl_we_n) if (armed) begin
    if (nwr < 8) begin wa[nwr] = fl_addr; wd[nwr] = fl_dq_o; end
    nwr++;
    if (!mbusy) begin
      case (mst)
        0: mst = (fl_addr == 12'h555 && fl_dq_o == 8'hAA) ? 1 : 0;
        1: mst = (fl_addr == 12'h2AA && fl_dq_o == 8'h55) ? 2 : 0;
        2: mst = (fl_addr == 12'h555 && fl_dq_o == 8'hA0) ? 3 : 0;
        default: begin
          mbusy = 1; maddr = fl_addr; mdat = fl_dq_o; mst = 0;
        end
      endcase
    end
  end

  always @(negedge fl_oe_n) if (armed) begin
    nrd++;
    if (fl_addr != cur_tgt) bad_rd++;
    tog = ~tog;
  end

  always @(negedge clk) if (mbusy && !mhang) begin
    if (mcnt <= 0) begin mem[maddr] = mem[maddr] & mdat; mbusy = 0; end
    else mcnt--;
  end

  // ---- write timing monitor (R3) ----
  int pre_c = 0, low_c = 0, post_c = 0;
  bit in_wr = 0, seen_low = 0;
  always @(negedge clk) if (armed) begin
    if (!fl_ce_n && fl_dq_oe) begin
      in_wr = 1;
      if (!fl_we_n) begin low_c++; seen_low = 1; end
      else if (!seen_low) pre_c++;
      else post_c++;
    end else if (in_wr) begin
      chk(pre_c == TS && low_c == TP && post_c == TH, "R3 write setup/pulse/hold",
          pre_c*256 + low_c*16 + post_c, TS*256 + TP*16 + TH);
      in_wr = 0; seen_low = 0; pre_c = 0; low_c = 0; post_c = 0;
    end
  end

  // 0 pass, 1 fail, 2 timeout
  function automatic int exp_code(input logic [7:0] old, input logic [7:0] d, input bit pre, input bit hang);
    logic [7:0] st = old & d;
    if (pre && st != d) return 1;
    if (hang || st[7] != d[7]) return 2;
    return (st == d) ? 0 : 1;
  endfunction

  task automatic run(input logic [AW-1:0] a, input logic [7:0] old, input logic [7:0] d,
                     input bit pre, input int lim, input bit hang, input int lat);
    int w = 0;
    int ec = exp_code(old, d, pre, hang);
    bit rejected = pre && ((old & d) != d);
    int elim = (lim == 0) ? 1 : lim;
    mem[a] = old; mbusy = 0; mhang = hang; mcnt = lat; mst = 0;
    nwr = 0; nrd = 0; bad_rd = 0; cur_tgt = a;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_data = d; req_precheck = pre; poll_limit = PW'(lim);
    @(negedge clk);
    // R1: a second request presented while busy must be ignored
    req_addr = a ^ 12'h001; req_data = ~d; req_precheck = 0; poll_limit = PW'(1);
    chk(req_ready == 0, "R1 ready low while busy", req_ready, 0);
    @(negedge clk);
    @(negedge clk);
    req_valid = 0;
    while (!done && w < 20000) begin @(negedge clk); w++; end
    chk(w < 20000, "R9 done within wait", w, 0);
    chk(pass == (ec == 0) && fail == (ec == 1) && timeout == (ec == 2),
        (ec == 2) ? "R8 result flags" : (rejected ? "R7 result flags" : "R6 result flags"),
        {pass, fail, timeout}, (ec == 0) ? 4 : (ec == 1) ? 2 : 1);
    if (rejected) begin
      chk(nwr == 0, "R7 no write on 0-to-1 reject", nwr, 0);
      chk(nrd == 1, "R7 one pre-check read", nrd, 1);
    end else begin
      chk(nwr == 4, "R2 write count", nwr, 4);
      chk(wa[0] == 12'h555 && wd[0] == 8'hAA && wa[1] == 12'h2AA && wd[1] == 8'h55 &&
          wa[2] == 12'h555 && wd[2] == 8'hA0, "R2 unlock/set-up order",
          {wa[2], wd[2]}, {12'h555, 8'hA0});
      chk(wa[3] == a && wd[3] == d, "R2 final write is target (R1 unchanged)",
          {wa[3], wd[3]}, {a, d});
      if (ec == 2)
        chk(nrd == elim + (pre ? 1 : 0), "R8 status read count", nrd, elim + (pre ? 1 : 0));
      else
        chk(nrd >= 2 + (pre ? 1 : 0), "R6 poll plus verify reads", nrd, 2 + (pre ? 1 : 0));
      chk(mem[a] == (hang ? old : (old & d)), "R6 stored value", mem[a], hang ? old : (old & d));
    end
    chk(bad_rd == 0, "R5 reads at target", bad_rd, 0);
    chk(req_ready == 1, "R1 ready after done", req_ready, 1);
    @(negedge clk);
    chk(done == 0, "R9 done single cycle", done, 0);
    mbusy = 0; mhang = 0;
  endtask

  initial begin
    #(4 * 200000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0011));
    for (int i = 0; i < (1 << AW); i++) mem[i] = 8'hFF;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R10
    chk(req_ready && fl_ce_n && fl_we_n && fl_oe_n && !fl_dq_oe && !done && !pass && !fail && !timeout,
        "R10 reset state", {req_ready, fl_ce_n, fl_we_n, fl_oe_n, fl_dq_oe, done, pass, fail, timeout},
        9'b111100000);
    armed = 1;
    run(12'h100, 8'hFF, 8'h5A, 0, 200, 0, 10);   // R6 normal pass
    run(12'h101, 8'hF0, 8'hF3, 1, 200, 0, 10);   // R7 reject, 0-to-1 in low bits
    run(12'h102, 8'hF0, 8'hF3, 0, 200, 0, 10);   // R6 false success caught by verify
    run(12'h103, 8'h0F, 8'h8F, 0, 200, 0, 10);   // R8 bit 7 conflict never completes
    run(12'h104, 8'hFF, 8'h12, 0, 3, 1, 0);      // R8 hung device, limit 3
    run(12'h105, 8'hFF, 8'h34, 1, 0, 1, 0);      // R8 limit 0 acts as 1
    run(12'h106, 8'hAB, 8'hAB, 1, 200, 0, 0);    // R7 pass-through, identical byte
    for (int k = 0; k < 40; k++) begin
      logic [7:0] o = 8'($urandom);
      logic [7:0] dd = ($urandom % 4 != 0) ? (o & 8'($urandom)) : 8'($urandom);
      run(AW'($urandom), o, dd, 1'($urandom % 2), 200, 0, 5 + int'($urandom % 50));
    end
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule